// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a byte-wide flash memory. Every write cycle on the device bus carries an address and a data byte. The decoder turns these writes into single-write commands and two-write command sequences. It picks what a read returns: the array, the identifier codes, or the status register. It also sends one-cycle start pulses, with an operation code, address and data, to an internal write state machine that is not part of this block.

Before an erase, a program or a lock-bit change may start, the decoder checks the lock-bit state against a high-voltage enable input. The lock-bit state is a per-block lock vector and a master lock flag, both supplied from outside. An operation that fails this check, or a sequence whose second write does not match, starts nothing. Instead it sets error bits, which a single clear command resets. While the write state machine is busy, the decoder honours only a status read and a suspend request. A confirm code written on its own later resumes the suspended operation.

All outputs are registered. They change on the clock edge that samples the bus write.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, rd_mode is 0 (array), op_start, sus_req and res_req are low, and status_err is 0.
- R2: A write of FFh, 90h or 70h sets rd_mode to 0 (array), 1 (identifier) or 2 (status) in the cycle after the write. A write of an unlisted code such as 33h changes no output.
- R3: A write of 50h clears all of status_err. The bits are: [0] protection, [1] lock-bit, [2] program, [3] erase, [4] sequence.
- R4: A write of 20h followed by a write of D0h gives an op_start pulse with op_kind 1 (erase) and op_addr set to the address of the D0h write.
- R5: A write of 40h or 10h, followed by any data byte, gives op_start with op_kind 2 (program), op_addr and op_data taken from that second write.
- R6: After 60h, a second byte of 01h gives op_kind 3 (set block lock), F1h gives op_kind 4 (set master lock), and D0h gives op_kind 5 (clear all block locks).
- R7: An erase or program aimed at a block whose blk_lock bit is set, with hv_en low, starts nothing. It sets status_err bit 0 together with bit 3 (erase) or bit 2 (program). The block index is the top BLK_W bits of the address.
- R8: Setting the master lock needs hv_en. Setting or clearing block locks needs hv_en only while master_lock is high. A refused lock command starts nothing and sets status_err bits 0 and 1.
- R9: A second write that is not a valid confirm for an erase or lock sequence starts nothing. It sets status_err bit 4 together with bit 3 (erase) or bit 1 (lock), and the decoder returns to idle.
- R10: While wsm_busy is high, only 70h (status mode) and B0h are honoured. B0h gives a one-cycle sus_req and enters the suspended state. All other writes are dropped.
- R11: While suspended, a lone D0h gives a one-cycle res_req and leaves the suspended state, and new erase, program and lock setups are ignored. A lone D0h when not suspended does nothing.
- R12: op_start, sus_req and res_req are single-cycle pulses, never high together, and are low in the cycle after a cycle with no bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write cycle, one clock wide |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | 8 | Write data byte |
| hv_en | input | 1 | High-voltage override enable |
| wsm_busy | input | 1 | Write state machine is running |
| blk_lock | input | 2**BLK_W | Lock bit per block |
| master_lock | input | 1 | Master lock bit |
| rd_mode | output | 2 | 0 array, 1 identifier, 2 status |
| op_start | output | 1 | Start pulse to the write state machine |
| op_kind | output | 3 | Operation code held with op_start |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 8 | Operation data byte |
| sus_req | output | 1 | Suspend pulse |
| res_req | output | 1 | Resume pulse |
| status_err | output | 5 | Sticky error bits |

## Verification
The assertions check on every cycle that:
- each pulse lasts one cycle and the pulses never overlap;
- a cycle with no write, or a write made while busy, starts nothing;
- an erase, program or master-lock start is always preceded by a write whose lock and high-voltage inputs allowed it;
- a suspend comes only from a busy cycle.

Some behaviour can only be shown by the bench's scenarios:
- which operation code and address come out of each sequence, including both program setup codes;
- how the error bits build up and clear;
- the sequence-error aborts;
- the suspend-then-resume order.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [2:0] OP_NONE        = 3'd0;
    localparam logic [2:0] OP_ERASE       = 3'd1;
    localparam logic [2:0] OP_PROG        = 3'd2;
    localparam logic [2:0] OP_LOCK_BLK    = 3'd3;
    localparam logic [2:0] OP_LOCK_MASTER = 3'd4;
    localparam logic [2:0] OP_UNLOCK_ALL  = 3'd5;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ERASE,
        SEQ_PROG,
        SEQ_LOCK
    } seq_e;

    localparam logic [7:0] C_ARRAY   = 8'hFF;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_STATUS  = 8'h70;
    localparam logic [7:0] C_CLEAR   = 8'h50;
    localparam logic [7:0] C_ERASE   = 8'h20;
    localparam logic [7:0] C_PROG_A  = 8'h40;
    localparam logic [7:0] C_PROG_B  = 8'h10;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_LOCK    = 8'h60;
    localparam logic [7:0] C_LK_BLK  = 8'h01;
    localparam logic [7:0] C_LK_MSTR = 8'hF1;

    localparam int ERR_W       = 5;
    localparam int ERR_PROTECT = 0;
    localparam int ERR_LOCK    = 1;
    localparam int ERR_PROG    = 2;
    localparam int ERR_ERASE   = 3;
    localparam int ERR_SEQ     = 4;
endpackage

// File: rtl/fcd_lock_gate.sv
module fcd_lock_gate
    import fcd_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       blk_locked,
    input  logic       master_lock,
    input  logic       hv_en,
    output logic       allow
);
    always_comb begin
        unique case (kind)
            OP_ERASE, OP_PROG:          allow = !blk_locked || hv_en;
            OP_LOCK_BLK, OP_UNLOCK_ALL: allow = !master_lock || hv_en;
            OP_LOCK_MASTER:             allow = hv_en;
            default:                    allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcd_err_reg.sv
module fcd_err_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    logic [W-1:0] err_d, err_q;

    always_comb begin
        if (clr) err_d = '0;
        else     err_d = err_q | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign q = err_q;
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_data,
    input  logic                  hv_en,
    input  logic                  wsm_busy,
    input  logic [(1<<BLK_W)-1:0] blk_lock,
    input  logic                  master_lock,
    output logic [1:0]            rd_mode,
    output logic                  op_start,
    output logic [2:0]            op_kind,
    output logic [ADDR_W-1:0]     op_addr,
    output logic [7:0]            op_data,
    output logic                  sus_req,
    output logic                  res_req,
    output logic [4:0]            status_err
);
    localparam int NBLK = 1 << BLK_W;

    typedef struct packed {
        seq_e              seq;
        rd_mode_e          mode;
        logic              susp;
        logic              start;
        logic [2:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              sus;
        logic              res;
    } state_t;

    state_t st_d, st_q;

    logic [BLK_W-1:0] blk_idx;
    logic             blk_locked;
    logic [2:0]       cand_kind;
    logic             allow;
    logic             err_clr;
    logic [ERR_W-1:0] err_set;

    assign blk_idx    = bus_addr[ADDR_W-1 -: BLK_W];
    assign blk_locked = blk_lock[blk_idx];

    // Operation that the pending sequence would start with this second byte.
    always_comb begin
        cand_kind = OP_NONE;
        unique case (st_q.seq)
            SEQ_ERASE: if (bus_data == C_CONFIRM) cand_kind = OP_ERASE;
            SEQ_PROG:  cand_kind = OP_PROG;
            SEQ_LOCK: begin
                if      (bus_data == C_LK_BLK)  cand_kind = OP_LOCK_BLK;
                else if (bus_data == C_LK_MSTR) cand_kind = OP_LOCK_MASTER;
                else if (bus_data == C_CONFIRM) cand_kind = OP_UNLOCK_ALL;
            end
            default: cand_kind = OP_NONE;
        endcase
    end

    fcd_lock_gate u_gate (
        .kind        (cand_kind),
        .blk_locked  (blk_locked),
        .master_lock (master_lock),
        .hv_en       (hv_en),
        .allow       (allow)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.sus   = 1'b0;
        st_d.res   = 1'b0;
        err_set    = '0;
        err_clr    = 1'b0;
        if (bus_wr) begin
            if (wsm_busy) begin
                if (bus_data == C_STATUS) begin
                    st_d.mode = RD_STATUS;
                end else if (bus_data == C_SUSPEND && !st_q.susp) begin
                    st_d.sus  = 1'b1;
                    st_d.susp = 1'b1;
                end
            end else if (st_q.seq != SEQ_IDLE) begin
                st_d.seq = SEQ_IDLE;
                if (cand_kind == OP_NONE) begin
                    err_set[ERR_SEQ] = 1'b1;
                    if (st_q.seq == SEQ_ERASE) err_set[ERR_ERASE] = 1'b1;
                    else                       err_set[ERR_LOCK]  = 1'b1;
                end else if (allow) begin
                    st_d.start = 1'b1;
                    st_d.kind  = cand_kind;
                    st_d.addr  = bus_addr;
                    st_d.data  = bus_data;
                end else begin
                    err_set[ERR_PROTECT] = 1'b1;
                    if      (cand_kind == OP_ERASE) err_set[ERR_ERASE] = 1'b1;
                    else if (cand_kind == OP_PROG)  err_set[ERR_PROG]  = 1'b1;
                    else                            err_set[ERR_LOCK]  = 1'b1;
                end
            end else begin
                unique case (bus_data)
                    C_ARRAY:  st_d.mode = RD_ARRAY;
                    C_IDENT:  st_d.mode = RD_IDENT;
                    C_STATUS: st_d.mode = RD_STATUS;
                    C_CLEAR:  err_clr   = 1'b1;
                    C_ERASE:  if (!st_q.susp) st_d.seq = SEQ_ERASE;
                    C_PROG_A,
                    C_PROG_B: if (!st_q.susp) st_d.seq = SEQ_PROG;
                    C_LOCK:   if (!st_q.susp) st_d.seq = SEQ_LOCK;
                    C_CONFIRM: begin
                        if (st_q.susp) begin
                            st_d.res  = 1'b1;
                            st_d.susp = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{seq: SEQ_IDLE, mode: RD_ARRAY, susp: 1'b0, start: 1'b0,
                      kind: OP_NONE, addr: '0, data: '0, sus: 1'b0, res: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    fcd_err_reg #(.W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .set   (err_set),
        .q     (status_err)
    );

    assign rd_mode  = st_q.mode;
    assign op_start = st_q.start;
    assign op_kind  = st_q.kind;
    assign op_addr  = st_q.addr;
    assign op_data  = st_q.data;
    assign sus_req  = st_q.sus;
    assign res_req  = st_q.res;

    logic unused_ok;
    assign unused_ok = ^{NBLK};
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  hv_en,
    input logic                  wsm_busy,
    input logic [(1<<BLK_W)-1:0] blk_lock,
    input logic [1:0]            rd_mode,
    input logic                  op_start,
    input logic [2:0]            op_kind,
    input logic                  sus_req,
    input logic                  res_req
);
    logic lock_ok;
    assign lock_ok = !blk_lock[bus_addr[ADDR_W-1 -: BLK_W]] || hv_en;

    assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({op_start, sus_req, res_req}) <= 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (!op_start && !sus_req && !res_req && $stable(rd_mode)));

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wsm_busy) |=> !op_start);

    assert_suspend_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sus_req |-> $past(wsm_busy && bus_wr));

    assert_lock_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && (op_kind == 3'd1 || op_kind == 3'd2)) |-> $past(lock_ok));

    assert_master_hv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd4) |-> $past(hv_en));
endmodule

bind flash_cmd_front fcd_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .hv_en    (hv_en),
    .wsm_busy (wsm_busy),
    .blk_lock (blk_lock),
    .rd_mode  (rd_mode),
    .op_start (op_start),
    .op_kind  (op_kind),
    .sus_req  (sus_req),
    .res_req  (res_req)
);

// File: tb/tb_flash_cmd_front.sv
module tb_flash_cmd_front;
    localparam int ADDR_W = 16;
    localparam int BLK_W  = 4;
    localparam int NBLK   = 1 << BLK_W;

    localparam logic [4:0] E_PROT = 5'd1, E_LOCK = 5'd2, E_PROG = 5'd4,
                           E_ERAS = 5'd8, E_SEQ  = 5'd16;

    typedef struct {
        logic              start;
        logic [2:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              sus;
        logic              res;
        logic [1:0]        mode;
        logic [4:0]        err;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_data;
    logic              hv_en;
    logic              wsm_busy;
    logic [NBLK-1:0]   blk_lock;
    logic              master_lock;
    logic [1:0]        rd_mode;
    logic              op_start;
    logic [2:0]        op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic              sus_req;
    logic              res_req;
    logic [4:0]        status_err;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_mode = 2'd0;
    logic [4:0] exp_err  = 5'd0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    flash_cmd_front #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .hv_en(hv_en), .wsm_busy(wsm_busy),
        .blk_lock(blk_lock), .master_lock(master_lock), .rd_mode(rd_mode),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .sus_req(sus_req), .res_req(res_req),
        .status_err(status_err)
    );

    // Monitor: compare the oldest expectation just after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic bad;
            e = exp_q.pop_front();
            bad = (op_start !== e.start) || (sus_req !== e.sus) ||
                  (res_req !== e.res) || (rd_mode !== e.mode) ||
                  (status_err !== e.err);
            if (e.start)
                bad = bad || (op_kind !== e.kind) || (op_addr !== e.addr) ||
                      (op_data !== e.data);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: got start=%0b kind=%0d addr=%h data=%h sus=%0b res=%0b mode=%0d err=%b, expected start=%0b kind=%0d addr=%h data=%h sus=%0b res=%0b mode=%0d err=%b",
                         e.tag, op_start, op_kind, op_addr, op_data, sus_req,
                         res_req, rd_mode, status_err, e.start, e.kind, e.addr,
                         e.data, e.sus, e.res, e.mode, e.err);
            end
        end
    end

    // Driver: one write, then the following idle cycle must be quiet (R12).
    task automatic drive(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input logic st, input logic [2:0] k,
                         input logic su, input logic re, input string tag);
        exp_t e;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_data = d;
        e = '{start: st, kind: k, addr: a, data: d, sus: su, res: re,
              mode: exp_mode, err: exp_err, tag: tag};
        exp_q.push_back(e);
        @(negedge clk);
        bus_wr = 1'b0;
        e = '{start: 1'b0, kind: 3'd0, addr: '0, data: '0, sus: 1'b0, res: 1'b0,
              mode: exp_mode, err: exp_err, tag: {tag, " R12 quiet after"}};
        exp_q.push_back(e);
    endtask

    task automatic wr_none(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
        drive(a, d, 1'b0, 3'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr_op(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input logic [2:0] k, input string tag);
        drive(a, d, 1'b1, k, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no end of test, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_data = '0;
        hv_en = 1'b0; wsm_busy = 1'b0; blk_lock = '0; master_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_mode !== 2'd0 || op_start !== 1'b0 || sus_req !== 1'b0 ||
            res_req !== 1'b0 || status_err !== 5'd0) begin
            errors++;
            $display("FAIL R1 reset: got mode=%0d start=%0b sus=%0b res=%0b err=%b, expected 0 0 0 0 00000",
                     rd_mode, op_start, sus_req, res_req, status_err);
        end

        // R2 read modes and unknown codes
        exp_mode = 2'd1; wr_none(16'h0000, 8'h90, "R2 identifier");
        exp_mode = 2'd2; wr_none(16'h0001, 8'h70, "R2 status");
        exp_mode = 2'd0; wr_none(16'h0002, 8'hFF, "R2 array");
        wr_none(16'h0003, 8'h33, "R2 unknown ignored");

        // R4 erase
        wr_none(16'h3000, 8'h20, "R4 erase setup");
        wr_op(16'h3010, 8'hD0, 3'd1, "R4 erase confirm");

        // R5 program with both setup codes
        wr_none(16'h5000, 8'h40, "R5 program setup 40");
        wr_op(16'h5004, 8'hAB, 3'd2, "R5 program 40 data");
        wr_none(16'h6000, 8'h10, "R5 program setup 10");
        wr_op(16'h6123, 8'h5C, 3'd2, "R5 program 10 data");

        // R7 locked block protection
        blk_lock[7] = 1'b1;
        wr_none(16'h7000, 8'h20, "R7 erase setup locked");
        exp_err = E_PROT | E_ERAS; wr_none(16'h7000, 8'hD0, "R7 erase refused");
        exp_err = 5'd0; wr_none(16'h0000, 8'h50, "R3 clear status");
        wr_none(16'h7000, 8'h40, "R7 program setup locked");
        exp_err = E_PROT | E_PROG; wr_none(16'h7002, 8'h99, "R7 program refused");
        exp_err = 5'd0; wr_none(16'h0000, 8'h50, "R3 clear again");
        hv_en = 1'b1;
        wr_none(16'h7000, 8'h20, "R7 erase setup hv");
        wr_op(16'h7000, 8'hD0, 3'd1, "R7 erase with hv");
        hv_en = 1'b0;

        // R9 sequence error
        wr_none(16'h3000, 8'h20, "R9 erase setup");
        exp_err = E_SEQ | E_ERAS; wr_none(16'h3000, 8'h55, "R9 erase bad confirm");
        exp_err = 5'd0; wr_none(16'h0000, 8'h50, "R3 clear seq");
        wr_none(16'h3000, 8'hD0, "R9 back to idle, lone D0 no effect");

        // R6 / R8 lock commands
        wr_none(16'h2000, 8'h60, "R6 lock setup");
        wr_op(16'h2000, 8'h01, 3'd3, "R6 set block lock");
        wr_none(16'h0000, 8'h60, "R8 master setup no hv");
        exp_err = E_PROT | E_LOCK; wr_none(16'h0000, 8'hF1, "R8 master refused");
        exp_err = 5'd0; wr_none(16'h0000, 8'h50, "R3 clear lock err");
        hv_en = 1'b1;
        wr_none(16'h0000, 8'h60, "R6 master setup hv");
        wr_op(16'h0000, 8'hF1, 3'd4, "R6 set master lock");
        hv_en = 1'b0; master_lock = 1'b1;
        wr_none(16'h0000, 8'h60, "R8 clear setup master set");
        exp_err = E_PROT | E_LOCK; wr_none(16'h0000, 8'hD0, "R8 clear refused");
        exp_err = 5'd0; wr_none(16'h0000, 8'h50, "R3 clear lock err 2");
        hv_en = 1'b1;
        wr_none(16'h0000, 8'h60, "R6 clear setup hv");
        wr_op(16'h0000, 8'hD0, 3'd5, "R6 clear all locks");
        hv_en = 1'b0; master_lock = 1'b0;
        wr_none(16'h0000, 8'h60, "R9 lock setup");
        exp_err = E_SEQ | E_LOCK; wr_none(16'h0000, 8'h77, "R9 lock bad second");
        exp_err = 5'd0; wr_none(16'h0000, 8'h50, "R3 clear");

        // R10 busy, R11 suspend and resume
        wsm_busy = 1'b1;
        wr_none(16'h0000, 8'h20, "R10 erase setup dropped");
        wr_none(16'h0000, 8'hFF, "R10 array dropped");
        exp_mode = 2'd2; wr_none(16'h0000, 8'h70, "R10 status honoured");
        drive(16'h0000, 8'hB0, 1'b0, 3'd0, 1'b1, 1'b0, "R10 suspend");
        wsm_busy = 1'b0;
        wr_none(16'h3000, 8'h20, "R11 erase setup ignored while suspended");
        drive(16'h3000, 8'hD0, 1'b0, 3'd0, 1'b0, 1'b1, "R11 resume");
        wr_none(16'h3000, 8'hD0, "R11 lone D0 not suspended");
        exp_mode = 2'd0; wr_none(16'h0000, 8'hFF, "R2 array after resume");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule